// File: doc/BRIEF.md
# Block-Transfer I2C Configuration Register Target

This block is a standard-mode I2C target (100 kbit/s or slower) that gives a host access to a bank of eight-bit configuration registers. It supports block transfers only. It answers to the 7-bit address 0x6A, which is 0xD4 as a write address byte and 0xD5 as a read address byte. A write carries a command byte and a byte-count byte. The block acknowledges both and ignores their values. Data bytes then fill the registers in ascending order, starting at register 0. A read returns a count byte equal to the number of registers, then register 0, register 1 and upward.

SCL and SDA are sampled by the system clock through a two-flop synchronizer. START and STOP are taken as SDA edges while SCL is high. The block drives SDA through an open-drain enable that pulls the line low. The register contents are presented in parallel on `cfg_out` for the logic that uses them.

Register 1 holds read-only bits. Its bits 1:0 read as constant 1. Its bits 5 and 4 mirror two strap inputs.

Top module: `blkreg_i2c_target`

## Requirements
- R1: After reset, register 0 holds 0x86, registers 2 and up hold 0xFF, register 1 reads 0xFF apart from its strap bits, and SDA is released (`sda_oe` = 0).
- R2: The address byte 0xD4 (write) or 0xD5 (read) is acknowledged: `sda_oe` pulls SDA low during the ninth SCL pulse of the byte.
- R3: Any other address gets no acknowledge. The block then leaves SDA released and ignores every byte until the next START or STOP.
- R4: In a write, the first two bytes after the address are acknowledged and their values are discarded. Each later byte is stored in register 0, 1, 2 and so on in that order. Register i appears on `cfg_out[8*i+7:8*i]`.
- R5: A STOP after any complete data byte ends the write. Bytes already received stay stored, and registers that were not reached keep their values.
- R6: Data bytes beyond the last register are acknowledged and discarded. No register changes.
- R7: Register 1 bits 1:0 always read 1. Register 1 bit 5 reads `strap_hi` and bit 4 reads `strap_lo`. Writes never change these four bits.
- R8: A read sends the register count (8) first, then register 0 upward, MSB first. Bytes requested after the last register read 0xFF.
- R9: When the host answers a read byte with NACK (SDA high on the ninth pulse), the block stops sending data and keeps SDA released until the next START.
- R10: A START in the middle of a transfer aborts it. A partly received byte is not stored, and a new address phase begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level (wired-AND of all drivers) |
| strap_hi | input | 1 | Strap level shown in register 1 bit 5 |
| strap_lo | input | 1 | Strap level shown in register 1 bit 4 |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| cfg_out | output | 64 | All registers, register i in bits 8*i+7 down to 8*i |

## Verification
A pin edge reaches the synchronized level on the second clock. Edge and START/STOP detection use that level together with the flop behind it. The protocol state and `sda_oe` respond on the clock after that, so the block reacts about four clocks after an SCL or SDA change. The bench divides each SCL bit into quarters of ten clocks. It drives SDA only while SCL is low, and it samples the line (and so the acknowledge or read data) ten clocks after SCL rises, well past that latency. Register values are checked on `cfg_out` after the STOP. By then the write commit, made at the SCL fall that ends the eighth bit, is long complete.

// File: rtl/blkreg_pkg.sv
// Package: shared protocol state type and per-register reset/read-only tables.
// Assumes register indices are small non-negative integers.
package blkreg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_SKIP
    } xfer_state_t;

    // Power-on value of register idx.
    function automatic logic [7:0] reg_default(input int idx);
        return (idx == 0) ? 8'h86 : 8'hFF;
    endfunction

    // Bits of register idx that a host write cannot change.
    function automatic logic [7:0] reg_ro_mask(input int idx);
        return (idx == 1) ? 8'h33 : 8'h00;
    endfunction

endpackage

// File: rtl/blkreg_bus_sampler.sv
// Bus sampler: synchronizes SCL/SDA into the system clock domain and flags
// SCL edges and START/STOP conditions, one clock pulse each.
// Assumes the system clock oversamples SCL by well over 8x.
module blkreg_bus_sampler #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC:0] scl_pipe;
    logic [SYNC:0] sda_pipe;
    logic          scl_lvl, scl_old, sda_old;

    // Shift the raw pins through the synchronizer and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC-1:0], scl_in};
            sda_pipe <= {sda_pipe[SYNC-1:0], sda_in};
        end
    end

    // Decode edges and bus conditions from current and previous levels.
    always_comb begin
        scl_lvl   = scl_pipe[SYNC-1];
        scl_old   = scl_pipe[SYNC];
        sda_lvl   = sda_pipe[SYNC-1];
        sda_old   = sda_pipe[SYNC];
        scl_rise  = scl_lvl & ~scl_old;
        scl_fall  = ~scl_lvl & scl_old;
        start_det = scl_lvl & scl_old & sda_old & ~sda_lvl;
        stop_det  = scl_lvl & scl_old & ~sda_old & sda_lvl;
    end

endmodule

// File: rtl/blkreg_regfile.sv
// Register bank: NREG eight-bit registers with per-register reset values and
// read-only masks from the package. Register 1 bits 5/4 show the straps.
// Assumes at most one write per clock and NREG >= 2.
module blkreg_regfile
    import blkreg_pkg::*;
#(
    parameter int NREG = 8,
    parameter int IDXW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDXW-1:0]   wr_idx,
    input  logic [7:0]        wr_data,
    input  logic              strap_hi,
    input  logic              strap_lo,
    output logic [NREG*8-1:0] vis
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [7:0] DEF  = reg_default(g);
        localparam logic [7:0] MASK = reg_ro_mask(g);
        logic [7:0] q;

        // Load the writable bits on a write hit; read-only bits keep their reset value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= DEF;
            end else if (wr_en && wr_idx == IDXW'(g)) begin
                q <= (wr_data & ~MASK) | (q & MASK);
            end
        end

        if (g == 1) begin : g_strap
            assign vis[8*g +: 8] = {q[7:6], strap_hi, strap_lo, q[3:0]};
        end else begin : g_plain
            assign vis[8*g +: 8] = q;
        end
    end

    // R6
    wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < IDXW'(NREG)));

endmodule

// File: rtl/blkreg_i2c_target.sv
// Top: I2C target for block writes (command + count bytes ignored, then data
// from register 0 upward) and block reads (count byte, then register 0 upward).
// Assumes SCL is slow against clk; SDA is open-drain, sda_oe=1 pulls it low.
module blkreg_i2c_target
    import blkreg_pkg::*;
#(
    parameter int         NREG  = 8,
    parameter logic [6:0] TADDR = 7'h6A,
    parameter int         SYNC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              strap_hi,
    input  logic              strap_lo,
    output logic              sda_oe,
    output logic [NREG*8-1:0] cfg_out
);
    localparam int IDXW = $clog2(NREG + 1);

    logic            sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    xfer_state_t     state;
    logic [3:0]      bitcnt;
    logic [7:0]      shreg, tx, rd_byte;
    logic            is_read;
    logic [1:0]      hdr_cnt;
    logic [IDXW-1:0] idx;
    logic            wr_en;

    blkreg_bus_sampler #(.SYNC(SYNC)) u_sampler (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    blkreg_regfile #(.NREG(NREG), .IDXW(IDXW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(idx),
        .wr_data(shreg), .strap_hi(strap_hi), .strap_lo(strap_lo), .vis(cfg_out)
    );

    // Commit a data byte at the SCL fall that ends its eighth bit.
    always_comb begin
        wr_en = (state == ST_WR_BYTE) && scl_fall && (bitcnt == 4'd8) &&
                (hdr_cnt == 2'd2) && (idx < IDXW'(NREG));
    end

    // Select the next read byte; 0xFF past the last register.
    always_comb begin
        rd_byte = 8'hFF;
        for (int i = 0; i < NREG; i++) begin
            if (idx == IDXW'(i)) rd_byte = cfg_out[8*i +: 8];
        end
    end

    // Open-drain drive: acknowledge slots and zero bits of read data.
    always_comb begin
        case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD_BYTE:             sda_oe = ~tx[7];
            default:                sda_oe = 1'b0;
        endcase
    end

    // Protocol sequencer: address, acknowledge, write and read byte phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            tx      <= '0;
            is_read <= 1'b0;
            hdr_cnt <= '0;
            idx     <= '0;
        end else if (start_det) begin
            state   <= ST_ADDR;
            bitcnt  <= '0;
            hdr_cnt <= '0;
            idx     <= '0;
        end else if (stop_det) begin
            state   <= ST_IDLE;
        end else begin
            case (state)
                ST_ADDR: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_lvl};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall && bitcnt == 4'd8) begin
                        if (shreg[7:1] == TADDR) begin
                            is_read <= shreg[0];
                            state   <= ST_ADDR_ACK;
                        end else begin
                            state   <= ST_SKIP;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (is_read) begin
                            tx    <= 8'(NREG);
                            state <= ST_RD_BYTE;
                        end else begin
                            state <= ST_WR_BYTE;
                        end
                    end
                end
                ST_WR_BYTE: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_lvl};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall && bitcnt == 4'd8) begin
                        state <= ST_WR_ACK;
                        if (hdr_cnt != 2'd2)           hdr_cnt <= hdr_cnt + 2'd1;
                        else if (idx < IDXW'(NREG))    idx     <= idx + 1'b1;
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        state  <= ST_WR_BYTE;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        tx     <= {tx[6:0], 1'b1};
                        bitcnt <= bitcnt + 4'd1;
                        if (bitcnt == 4'd7) state <= ST_RD_ACK;
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise && sda_lvl) begin
                        state <= ST_SKIP;
                    end else if (scl_fall) begin
                        tx     <= rd_byte;
                        bitcnt <= '0;
                        state  <= ST_RD_BYTE;
                        if (idx < IDXW'(NREG)) idx <= idx + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R2
    addr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && scl_fall && bitcnt == 4'd8 && shreg[7:1] == TADDR) |=> sda_oe);

    // R3
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R4
    write_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (state == ST_WR_ACK));

    // R7
    ro_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_out[9:8] == 2'b11) && (cfg_out[13:12] == {strap_hi, strap_lo}));

    // R9
    nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_ACK && scl_rise && sda_lvl) |=> (state == ST_SKIP && !sda_oe));

    // R10
    start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR && bitcnt == 4'd0));

endmodule

// File: tb/blkreg_i2c_target_test.sv
module blkreg_i2c_target_test;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;   // clocks per quarter SCL bit
    localparam int NREG       = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_scl = 1'b1;
    logic host_sda = 1'b1;
    logic strap_hi = 1'b0;
    logic strap_lo = 1'b0;
    logic sda_oe;
    logic [NREG*8-1:0] cfg_out;
    wire  sda_line = host_sda & ~sda_oe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blkreg_i2c_target uut (
        .clk(clk), .rst_n(rst_n), .scl_in(host_scl), .sda_in(sda_line),
        .strap_hi(strap_hi), .strap_lo(strap_lo), .sda_oe(sda_oe), .cfg_out(cfg_out)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] reg_at(input int i);
        return cfg_out[8*i +: 8];
    endfunction

    task automatic bus_start();
        host_sda = 1'b1; tick(Q);
        host_scl = 1'b1; tick(Q);
        host_sda = 1'b0; tick(Q);
        host_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; tick(Q);
        host_scl = 1'b1; tick(Q);
        host_sda = 1'b1; tick(2*Q);
    endtask

    task automatic send_bit(input logic b);
        host_sda = b;    tick(Q);
        host_scl = 1'b1; tick(2*Q);
        host_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_bit(output logic b);
        host_sda = 1'b1; tick(Q);
        host_scl = 1'b1; tick(Q);
        b = sda_line;    tick(Q);
        host_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(a);
        acked = ~a;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic nack);
        for (int i = 7; i >= 0; i--) recv_bit(d[i]);
        send_bit(nack);
    endtask

    // R1: reset values and released SDA
    task automatic t_reset();
        chk("R1 sda released", sda_oe, 1'b0);
        chk("R1 reg0 default", reg_at(0), 8'h86);
        chk("R1 reg1 default", reg_at(1), 8'hCF);
        chk("R1 reg7 default", reg_at(7), 8'hFF);
    endtask

    // R2 R4 R7: block write of three data bytes
    task automatic t_block_write();
        logic a;
        bus_start();
        send_byte(8'hD4, a); chk("R2 write address ack", a, 1'b1);
        send_byte(8'h55, a); chk("R4 command ack", a, 1'b1);
        send_byte(8'h03, a); chk("R4 count ack", a, 1'b1);
        send_byte(8'h12, a);
        send_byte(8'hAB, a);
        send_byte(8'h3C, a); chk("R4 data ack", a, 1'b1);
        bus_stop();
        chk("R4 reg0", reg_at(0), 8'h12);
        chk("R7 reg1 ro bits kept", reg_at(1), 8'h8B);
        chk("R4 reg2", reg_at(2), 8'h3C);
        chk("R4 reg3 untouched", reg_at(3), 8'hFF);
    endtask

    // R5: stop after one data byte
    task automatic t_partial_write();
        logic a;
        bus_start();
        send_byte(8'hD4, a);
        send_byte(8'h00, a);
        send_byte(8'h00, a);
        send_byte(8'h77, a);
        bus_stop();
        chk("R5 reg0 stored", reg_at(0), 8'h77);
        chk("R5 reg1 kept", reg_at(1), 8'h8B);
        chk("R5 reg2 kept", reg_at(2), 8'h3C);
    endtask

    // R9: NACK on count byte ends output
    task automatic t_read_nack();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(8'hD5, a); chk("R2 read address ack", a, 1'b1);
        recv_byte(d, 1'b1);  chk("R8 count byte", d, 8'h08);
        for (int i = 7; i >= 0; i--) recv_bit(d[i]);
        chk("R9 released after nack", d, 8'hFF);
        bus_stop();
    endtask

    // R3: foreign address ignored
    task automatic t_wrong_addr();
        logic a;
        bus_start();
        send_byte(8'hA4, a); chk("R3 no address ack", a, 1'b0);
        send_byte(8'h00, a); chk("R3 no ack after mismatch", a, 1'b0);
        send_byte(8'h00, a);
        send_byte(8'h00, a);
        bus_stop();
        chk("R3 reg0 unchanged", reg_at(0), 8'h77);
    endtask

    // R10: repeated START in the middle of a data byte
    task automatic t_restart_abort();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(8'hD4, a);
        send_byte(8'h00, a);
        send_byte(8'h00, a);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_start();
        send_byte(8'hD5, a); chk("R10 new address ack", a, 1'b1);
        recv_byte(d, 1'b0);
        recv_byte(d, 1'b1); chk("R10 partial byte not stored", d, 8'h77);
        bus_stop();
        chk("R10 reg0 port", reg_at(0), 8'h77);
    endtask

    // R6: ten data bytes into eight registers
    task automatic t_overflow_write();
        logic a;
        bus_start();
        send_byte(8'hD4, a);
        send_byte(8'h01, a);
        send_byte(8'h0A, a);
        for (int i = 0; i < 10; i++) begin
            send_byte(8'hA0 + 8'(i), a);
            if (i >= 8) chk("R6 extra byte ack", a, 1'b1);
        end
        bus_stop();
        chk("R6 reg0", reg_at(0), 8'hA0);
        chk("R6 reg1", reg_at(1), 8'h83);
        chk("R6 reg7 last", reg_at(7), 8'hA7);
    endtask

    // R7 R8: straps and full read with one byte past the end
    task automatic t_read_all();
        logic a;
        logic [7:0] d;
        logic [7:0] exp;
        strap_hi = 1'b1;
        strap_lo = 1'b0;
        tick(4);
        chk("R7 strap bits on port", reg_at(1), 8'hA3);
        bus_start();
        send_byte(8'hD5, a);
        recv_byte(d, 1'b0); chk("R8 count", d, 8'h08);
        for (int i = 0; i < NREG; i++) begin
            recv_byte(d, 1'b0);
            exp = (i == 1) ? 8'hA3 : 8'hA0 + 8'(i);
            chk("R8 register data", d, exp);
        end
        recv_byte(d, 1'b1); chk("R8 past end", d, 8'hFF);
        bus_stop();
        chk("R9 released at end", sda_oe, 1'b0);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_block_write();
        t_partial_write();
        t_read_nack();
        t_wrong_addr();
        t_restart_abort();
        t_overflow_write();
        t_read_all();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule